// File: doc/BRIEF.md
# Run-Time Reconfigurable Fractional-N Noise Shaper

This block turns a fixed-point fraction into a stream of small signed integers whose long-run average equals that fraction. A fractional-N synthesiser adds each integer to its integer division ratio, once per reference clock. Quantisation error is pushed toward high frequencies by an error-feedback loop. The loop's noise transfer function is chosen at run time by a 2-bit order code: first order, second order, third order as a pure cascade of differences, or a third-order variant with one of its three zeros pulled off DC for extra margin.

Every quantiser decision is limited to a programmable signed window before it is emitted and before it is fed back. The integer path can therefore never ask the divider for a step it cannot take. The stored error history is saturated, so an overloaded loop stays bounded. Changing the order code flushes the history before the new structure starts. No state left over from the old topology can disturb the first samples of the new one.

Top module: `dsm_frac_mod`

## Requirements
- R1: While `rst_n` is low, `offset_out` is 0, `offset_valid` is 0, the three stored errors are 0 and the active order is code 00.
- R2: On a clock edge with `enable` high and `order_sel` equal to the active order, one sample is made: `offset_out` takes the clamped decision and `offset_valid` goes high. On an edge with `enable` low and no order change, `offset_valid` goes low and `offset_out` and the stored errors keep their values.
- R3: With x = `frac_in` (unsigned) and e1, e2, e3 the stored errors of the last three samples (e1 newest), the loop value v is x+e1 for code 00, x+2·e1−e2 for code 01, and x+3·e1−3·e2+e3 for code 10.
- R4: For code 11, v = x + 2·e1 + (e1>>>1) − 2·e2 + (e3>>>1), where >>> is an arithmetic shift that rounds toward minus infinity.
- R5: The raw decision is floor((v + 2^23) / 2^24). The new error is v − y·2^24, where y is the decision after clamping. That error becomes e1, and the older errors shift down one place.
- R6: `lim_hi` and `lim_lo` are 4-bit two's-complement values (−8 to +7). A raw decision above `lim_hi` becomes `lim_hi`. Otherwise, one below `lim_lo` becomes `lim_lo`. So with `lim_lo` ≤ `lim_hi` every valid sample lies in [`lim_lo`, `lim_hi`], and with `lim_hi` < `lim_lo` every valid sample is one of the two limits.
- R7: Each new error is saturated to the range [−2^26, 2^26−1] before it is stored.
- R8: On a clock edge where `order_sel` differs from the active order, whatever `enable` is: the stored errors clear to 0, the active order takes `order_sel`, `offset_out` goes to 0 and `offset_valid` goes low. No sample is made on that edge.
- R9: With a constant fraction and limits wide enough to avoid overload, the sum of the outputs over N samples is within 8 of N·x/2^24. This holds for every order code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Make one sample on this edge |
| frac_in | input | 24 | Unsigned fraction, units of 2^-24 |
| order_sel | input | 2 | Order code: 00 first, 01 second, 10 third cascade, 11 third with off-DC zero |
| lim_hi | input | 4 | Signed upper clamp for the decision |
| lim_lo | input | 4 | Signed lower clamp for the decision |
| offset_out | output | 4 | Signed divider offset |
| offset_valid | output | 1 | High for one cycle after each sample |

## Verification
Two things can happen on the same edge: an order change and a request to sample. The bench moves `order_sel` while `enable` is held high, in the middle of a running stream. It expects the blanked zero output with no valid strobe, followed by samples computed from a cleared history under the new equation. A cycle-by-cycle behavioural model checks every edge. The clamp and the error saturation also meet on the same edge: a near-full fraction under a ±1 window drives the third-order loop into overload. The model's saturated history must then track the design sample for sample, including after the limits are crossed so that the upper limit is below the lower one.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
   typedef enum logic [1:0] {
      ORD_FIRST  = 2'b00,
      ORD_SECOND = 2'b01,
      ORD_THIRD  = 2'b10,
      ORD_THIRD_OFFDC = 2'b11
   } dsm_order_e;

   localparam int unsigned HIST_TAPS = 3;
endpackage

// File: rtl/dsm_err_history.sv
module dsm_err_history #(
   parameter int unsigned EW   = 27,
   parameter int unsigned TAPS = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     shift,
   input  logic [EW-1:0]            err_in,
   output logic [TAPS-1:0][EW-1:0]  taps_o
);
   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      logic [EW-1:0] src;
      if (t == 0) begin : g_head
         assign src = err_in;
      end else begin : g_body
         assign src = taps_o[t-1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            taps_o[t] <= '0;
         end else if (shift) begin
            taps_o[t] <= src;
         end
      end
   end
endmodule

// File: rtl/dsm_noise_filter.sv
module dsm_noise_filter
   import dsm_pkg::*;
#(
   parameter int unsigned FW     = 24,
   parameter int unsigned EW     = 27,
   parameter int unsigned VW     = 31,
   parameter bit          OFFDC_EN = 1'b1
) (
   input  logic [FW-1:0]        frac,
   input  dsm_order_e           order,
   input  logic [EW-1:0]        e1,
   input  logic [EW-1:0]        e2,
   input  logic [EW-1:0]        e3,
   output logic signed [VW-1:0] loop_v
);
   logic signed [VW-1:0] xs, s1, s2, s3, third_cascade, third_offdc;

   always_comb begin
      xs = VW'(frac);
      s1 = VW'($signed(e1));
      s2 = VW'($signed(e2));
      s3 = VW'($signed(e3));
      third_cascade = xs + (s1 <<< 1) + s1 - (s2 <<< 1) - s2 + s3;
   end

   if (OFFDC_EN) begin : g_offdc
      always_comb third_offdc = xs + (s1 <<< 1) + (s1 >>> 1) - (s2 <<< 1) + (s3 >>> 1);
   end else begin : g_no_offdc
      always_comb third_offdc = third_cascade;
   end

   always_comb begin
      unique case (order)
         ORD_FIRST:  loop_v = xs + s1;
         ORD_SECOND: loop_v = xs + (s1 <<< 1) - s2;
         ORD_THIRD:  loop_v = third_cascade;
         default:    loop_v = third_offdc;
      endcase
   end
endmodule

// File: rtl/dsm_quant_clamp.sv
module dsm_quant_clamp #(
   parameter int unsigned FW = 24,
   parameter int unsigned EW = 27,
   parameter int unsigned VW = 31,
   parameter int unsigned OW = 4
) (
   input  logic signed [VW-1:0] loop_v,
   input  logic [OW-1:0]        lim_hi,
   input  logic [OW-1:0]        lim_lo,
   output logic [OW-1:0]        decision,
   output logic [EW-1:0]        err_sat
);
   localparam logic signed [VW-1:0] HALF = VW'(1) <<< (FW - 1);
   localparam logic signed [VW-1:0] EMAX = (VW'(1) <<< (EW - 1)) - VW'(1);
   localparam logic signed [VW-1:0] EMIN = -(VW'(1) <<< (EW - 1));

   logic signed [VW-1:0] raw, hi_w, lo_w, y_w, err_w;

   always_comb begin
      raw  = (loop_v + HALF) >>> FW;
      hi_w = VW'($signed(lim_hi));
      lo_w = VW'($signed(lim_lo));
      if (raw > hi_w) begin
         y_w = hi_w;
      end else if (raw < lo_w) begin
         y_w = lo_w;
      end else begin
         y_w = raw;
      end
      err_w = loop_v - (y_w <<< FW);
      if (err_w > EMAX) begin
         err_sat = EW'(EMAX);
      end else if (err_w < EMIN) begin
         err_sat = EW'(EMIN);
      end else begin
         err_sat = EW'(err_w);
      end
      decision = OW'(y_w);
   end
endmodule

// File: rtl/dsm_frac_mod.sv
module dsm_frac_mod
   import dsm_pkg::*;
#(
   parameter int unsigned FRAC_W   = 24,
   parameter int unsigned OUT_W    = 4,
   parameter int unsigned GUARD_W  = 2,
   parameter bit          OFFDC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [FRAC_W-1:0] frac_in,
   input  logic [1:0]        order_sel,
   input  logic [OUT_W-1:0]  lim_hi,
   input  logic [OUT_W-1:0]  lim_lo,
   output logic [OUT_W-1:0]  offset_out,
   output logic              offset_valid
);
   localparam int unsigned ERR_W  = FRAC_W + GUARD_W + 1;
   localparam int unsigned LOOP_W = ERR_W + 4;

   if (FRAC_W < 8 || FRAC_W > 40) begin : g_bad_frac
      $error("dsm_frac_mod: FRAC_W out of range");
   end
   if (OUT_W < 3 || OUT_W > 8) begin : g_bad_out
      $error("dsm_frac_mod: OUT_W out of range");
   end
   if (GUARD_W < 1 || GUARD_W > 6) begin : g_bad_guard
      $error("dsm_frac_mod: GUARD_W out of range");
   end

   dsm_order_e                           order_act;
   logic                                 order_switch;
   logic [HIST_TAPS-1:0][ERR_W-1:0]      hist;
   logic signed [LOOP_W-1:0]             loop_v;
   logic [OUT_W-1:0]                     decision;
   logic [ERR_W-1:0]                     err_new;

   assign order_switch = (order_sel != order_act);

   dsm_err_history #(.EW(ERR_W), .TAPS(HIST_TAPS)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (order_switch),
      .shift  (enable && !order_switch),
      .err_in (err_new),
      .taps_o (hist)
   );

   dsm_noise_filter #(.FW(FRAC_W), .EW(ERR_W), .VW(LOOP_W), .OFFDC_EN(OFFDC_EN)) u_filt (
      .frac   (frac_in),
      .order  (order_act),
      .e1     (hist[0]),
      .e2     (hist[1]),
      .e3     (hist[2]),
      .loop_v (loop_v)
   );

   dsm_quant_clamp #(.FW(FRAC_W), .EW(ERR_W), .VW(LOOP_W), .OW(OUT_W)) u_quant (
      .loop_v   (loop_v),
      .lim_hi   (lim_hi),
      .lim_lo   (lim_lo),
      .decision (decision),
      .err_sat  (err_new)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         order_act    <= ORD_FIRST;
         offset_out   <= '0;
         offset_valid <= 1'b0;
      end else if (order_switch) begin
         order_act    <= dsm_order_e'(order_sel);
         offset_out   <= '0;
         offset_valid <= 1'b0;
      end else if (enable) begin
         offset_out   <= decision;
         offset_valid <= 1'b1;
      end else begin
         offset_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/dsm_frac_mod_chk.sv
module dsm_frac_mod_chk #(
   parameter int unsigned OUT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [1:0]       order_sel,
   input logic [1:0]       order_act,
   input logic [OUT_W-1:0] lim_hi,
   input logic [OUT_W-1:0] lim_lo,
   input logic [OUT_W-1:0] offset_out,
   input logic             offset_valid
);
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(!enable)) |-> !offset_valid); // R2

   AST_IDLE_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(!enable) && $past(order_sel == order_act)) |-> $stable(offset_out)); // R2

   AST_SWITCH_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(order_sel != order_act)) |-> (!offset_valid && offset_out == '0)); // R8

   AST_SWITCH_ADOPTS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(order_sel != order_act)) |-> (order_act == $past(order_sel))); // R8

   AST_WITHIN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && offset_valid && $past($signed(lim_lo) <= $signed(lim_hi)))
      |-> ($signed(offset_out) <= $signed($past(lim_hi)) &&
           $signed(offset_out) >= $signed($past(lim_lo)))); // R6

   AST_CROSSED_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && offset_valid && $past($signed(lim_hi) < $signed(lim_lo)))
      |-> (offset_out == $past(lim_hi) || offset_out == $past(lim_lo))); // R6
endmodule

bind dsm_frac_mod dsm_frac_mod_chk #(.OUT_W(OUT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable       (enable),
   .order_sel    (order_sel),
   .order_act    (order_act),
   .lim_hi       (lim_hi),
   .lim_lo       (lim_lo),
   .offset_out   (offset_out),
   .offset_valid (offset_valid)
);

// File: tb/dsm_frac_mod_test.sv
module dsm_frac_mod_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [23:0] frac_in = '0;
   logic [1:0]  order_sel = 2'b00;
   logic [3:0]  lim_hi = 4'b0011;
   logic [3:0]  lim_lo = 4'b1100;
   logic [3:0]  offset_out;
   logic        offset_valid;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   string tag = "R1";

   longint me1, me2, me3;
   int     mact, mout;
   bit     mval;

   always #10 clk = ~clk;

   dsm_frac_mod uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .frac_in(frac_in),
      .order_sel(order_sel), .lim_hi(lim_hi), .lim_lo(lim_lo),
      .offset_out(offset_out), .offset_valid(offset_valid)
   );

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      for (int c = 0; c < 190000; c++) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
         report();
         $finish;
      end
   end

   task automatic check_int(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Behavioural reference of one clock edge, from the requirements.
   task automatic model_edge(bit en, longint x, int ord, int hi, int lo);
      longint v, yr, y, e;
      longint emax = (64'sd1 <<< 26) - 1;
      longint emin = -(64'sd1 <<< 26);
      if (ord != mact) begin
         me1 = 0; me2 = 0; me3 = 0; mact = ord; mout = 0; mval = 0;   // R8
      end else if (en) begin
         case (mact)
            0: v = x + me1;                                         // R3
            1: v = x + 2*me1 - me2;                                 // R3
            2: v = x + 3*me1 - 3*me2 + me3;                         // R3
            default: v = x + 2*me1 + (me1 >>> 1) - 2*me2 + (me3 >>> 1); // R4
         endcase
         yr = (v + (64'sd1 <<< 23)) >>> 24;                          // R5
         if (yr > hi) y = hi; else if (yr < lo) y = lo; else y = yr; // R6
         e = v - y * (64'sd1 <<< 24);
         if (e > emax) e = emax; else if (e < emin) e = emin;        // R7
         me3 = me2; me2 = me1; me1 = e;
         mout = int'(y); mval = 1;
      end else begin
         mval = 0;                                                   // R2
      end
   endtask

   task automatic step(bit en, logic [23:0] x, logic [1:0] ord, logic [3:0] hi, logic [3:0] lo);
      enable = en; frac_in = x; order_sel = ord; lim_hi = hi; lim_lo = lo;
      model_edge(en, longint'(x), int'(ord), int'($signed(hi)), int'($signed(lo)));
      @(posedge clk);
      @(negedge clk);
      check_int(tag, int'($signed(offset_out)), mout);
      check_int(tag, int'(offset_valid), int'(mval));
      if (offset_valid && $signed(hi) >= $signed(lo)) begin
         checks++;
         if ($signed(offset_out) > $signed(hi) || $signed(offset_out) < $signed(lo)) begin
            failures++;
            $display("FAIL R6: actual %0d expected within [%0d,%0d]",
                     $signed(offset_out), $signed(lo), $signed(hi));
         end
      end
   endtask

   task automatic run_mean(logic [1:0] ord, logic [23:0] x, logic [3:0] hi, logic [3:0] lo, int n);
      longint sum = 0;
      longint diff;
      step(1'b1, x, ord, hi, lo);
      for (int i = 0; i < n; i++) begin
         step(1'b1, x, ord, hi, lo);
         sum += longint'($signed(offset_out));
      end
      diff = sum * (64'sd1 <<< 24) - longint'(x) * longint'(n);
      if (diff < 0) diff = -diff;
      checks++;
      if (diff > 8 * (64'sd1 <<< 24)) begin
         failures++;
         $display("FAIL R9: actual sum %0d expected about %0d (order %0d)",
                  sum, (longint'(x) * n) >>> 24, ord);
      end
   endtask

   initial begin
      me1 = 0; me2 = 0; me3 = 0; mact = 0; mout = 0; mval = 0;
      repeat (3) @(negedge clk);
      tag = "R1";
      check_int("R1", int'(offset_out), 0);
      check_int("R1", int'(offset_valid), 0);
      rst_n = 1'b1;

      tag = "R3";
      for (int i = 0; i < 40; i++) step(1'b1, 24'h400000, 2'b00, 4'b0011, 4'b1100);
      tag = "R2";
      for (int i = 0; i < 5; i++) step(1'b0, 24'hFFFFFF, 2'b00, 4'b0011, 4'b1100);
      for (int i = 0; i < 10; i++) step(1'b1, 24'h9A0000, 2'b00, 4'b0011, 4'b1100);

      tag = "R8";
      step(1'b1, 24'h9A0000, 2'b01, 4'b0011, 4'b1100);
      tag = "R3";
      for (int i = 0; i < 40; i++) step(i % 7 != 3, 24'h2B5C11, 2'b01, 4'b0011, 4'b1100);
      tag = "R8";
      step(1'b0, 24'h2B5C11, 2'b11, 4'b0111, 4'b1000);
      tag = "R4";
      for (int i = 0; i < 40; i++) step(1'b1, 24'hD00001, 2'b11, 4'b0111, 4'b1000);

      tag = "R7";
      step(1'b1, 24'hF00000, 2'b10, 4'b0001, 4'b1111);
      for (int i = 0; i < 200; i++) step(1'b1, 24'hF00000, 2'b10, 4'b0001, 4'b1111);
      tag = "R6";
      for (int i = 0; i < 50; i++) step(1'b1, 24'h700000, 2'b10, 4'b1110, 4'b0010);
      for (int i = 0; i < 30; i++) step(1'b1, 24'h123456, 2'b10, 4'b0000, 4'b0000);

      tag = "R9";
      run_mean(2'b00, 24'h555555, 4'b0011, 4'b1100, 65536);
      run_mean(2'b01, 24'h123456, 4'b0011, 4'b1100, 65536);
      run_mean(2'b10, 24'hABCDEF, 4'b0111, 4'b1000, 16384);
      run_mean(2'b11, 24'h3F0000, 4'b0111, 4'b1000, 16384);

      finished = 1;
      report();
      $finish;
   end
endmodule